// File: doc/BRIEF.md
# Gated Pixel Row/Column Selector

This block is a serial-in, parallel-out chain that drives the selection lines of a 16 x 16 pixel matrix. One bit arrives on the serial input at each rising edge of the shift clock. After the chain is full, raising the enable input passes the stored pattern to the matrix. While enable is low, every parallel output reads zero, so the matrix does not see the bits moving through the chain during loading. A serial output shows the cell at the exit end of the chain, which allows test readback and daisy-chaining.

The chain length is a parameter with two legal values. With 16 cells, the block selects one column for analog readout. With 32 cells, the lower half selects columns and the upper half selects rows. This form is used for charge injection and digital readout.

Four flags report on the stored pattern and do not depend on enable:
- a column flag that is high when the column half holds exactly one 1;
- a row flag that is high when the row half holds exactly one 1;
- a flag that is high when exactly one pixel is addressed;
- a flag that is high when more than one line is driven in either half.

These flags let the loading side confirm the pattern before it is applied. In injection mode several ones are allowed. Every crossing of a selected row and a selected column is then addressed, including unintended ghost pixels.

Top module: `pixsel_sr`

## Requirements
- R1: Parameter LEN takes the value 16 or 32 (default 32). With LEN=16, the whole chain is a single column half.
- R2: At each rising edge of clk_sh, ser_in enters cell LEN-1 and every cell k takes the old value of cell k+1. After LEN edges, the bit sent first sits in cell 0 and the bit sent last sits in cell LEN-1.
- R3: An active-low rst_n clears every cell to 0 at once, without waiting for a clock edge.
- R4: Each sel_out[k] equals cell k AND sel_en. While sel_en is low, sel_out is all zeros, including during loading.
- R5: When LEN=32, sel_out[15:0] drive columns 15..0 and sel_out[31:16] drive rows 15..0. Stream bit k selects column k for k<16 and row k-16 for k>=16.
- R6: ser_out always presents cell 0, which is the bit that leaves the chain next. It is not gated by sel_en.
- R7: col_onehot is high exactly when cells 15:0 contain a single 1, whatever the level of sel_en.
- R8: row_onehot is high exactly when cells 31:16 contain a single 1. With LEN=16 it is held at 1.
- R9: single_pixel is high exactly when col_onehot and row_onehot are both high.
- R10: multi_select is high when either half contains two or more 1s.
- R11: Changing sel_en between clock edges changes neither the stored cells nor the flags.
- R12: While sel_en is high, shifting continues, and sel_out follows the new contents after every edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_sh | input | 1 | Shift clock; data is captured on the rising edge |
| rst_n | input | 1 | Asynchronous active-low clear of all cells |
| ser_in | input | 1 | Serial data input |
| sel_en | input | 1 | Gate for the parallel outputs, active high |
| sel_out | output | LEN | Gated selection lines (columns low, rows high) |
| ser_out | output | 1 | Exit cell of the chain |
| col_onehot | output | 1 | Column half holds exactly one 1 |
| row_onehot | output | 1 | Row half holds exactly one 1 (1 when LEN=16) |
| single_pixel | output | 1 | Exactly one pixel addressed |
| multi_select | output | 1 | Some half holds more than one 1 |

## Verification
Two actions can meet at the same clock edge: a shift, and the output gating while sel_en is high. With the gate open, a shift edge must move the visible pattern by one place and insert the new serial bit at the top, with no stale or zero cycle in between. The bench opens the gate on an empty chain and shifts a lone 1 through it. It compares sel_out after each edge against the one-place move it predicts. It also toggles sel_en between edges to show that the gate and the stored contents are separate. An asynchronous reset applied in the middle of a cycle, with the gate open, must clear the outputs and the flags before the next edge.

// File: rtl/pixsel_pkg.sv
package pixsel_pkg;

    localparam int HALF_W = 16;

    typedef enum logic [1:0] {
        OCC_NONE = 2'd0,
        OCC_ONE  = 2'd1,
        OCC_MANY = 2'd2
    } occ_e;

    function automatic occ_e classify(input logic [HALF_W-1:0] bits);
        logic [1:0] seen;
        seen = 2'd0;
        for (int i = 0; i < HALF_W; i++) begin
            if (bits[i]) begin
                seen = (seen == 2'd0) ? 2'd1 : 2'd2;
            end
        end
        unique case (seen)
            2'd0:    return OCC_NONE;
            2'd1:    return OCC_ONE;
            default: return OCC_MANY;
        endcase
    endfunction

endpackage

// File: rtl/pixsel_chain.sv
module pixsel_chain #(
    parameter int LEN = 32
) (
    input  logic           clk_sh,
    input  logic           rst_n,
    input  logic           ser_in,
    output logic [LEN-1:0] cells,
    output logic           ser_out
);

    always_ff @(posedge clk_sh or negedge rst_n) begin
        if (!rst_n) begin
            cells <= '0;
        end else begin
            cells <= {ser_in, cells[LEN-1:1]};
        end
    end

    assign ser_out = cells[0];

endmodule

// File: rtl/pixsel_gate.sv
module pixsel_gate #(
    parameter int LEN = 32
) (
    input  logic [LEN-1:0] cells,
    input  logic           sel_en,
    output logic [LEN-1:0] sel_out
);

    for (genvar g = 0; g < LEN; g++) begin : g_and
        assign sel_out[g] = cells[g] & sel_en;
    end

endmodule

// File: rtl/pixsel_occ.sv
module pixsel_occ
    import pixsel_pkg::*;
(
    input  logic [HALF_W-1:0] bits,
    output occ_e              occ
);

    always_comb begin
        occ = classify(bits);
    end

endmodule

// File: rtl/pixsel_sr.sv
module pixsel_sr
    import pixsel_pkg::*;
#(
    parameter int LEN = 32
) (
    input  logic           clk_sh,
    input  logic           rst_n,
    input  logic           ser_in,
    input  logic           sel_en,
    output logic [LEN-1:0] sel_out,
    output logic           ser_out,
    output logic           col_onehot,
    output logic           row_onehot,
    output logic           single_pixel,
    output logic           multi_select
);

    localparam int NUM_HALF = LEN / HALF_W;

    logic [LEN-1:0] cells;
    occ_e           half_occ [NUM_HALF];
    logic [NUM_HALF-1:0] half_many;

    pixsel_chain #(.LEN(LEN)) chain_i (
        .clk_sh (clk_sh),
        .rst_n  (rst_n),
        .ser_in (ser_in),
        .cells  (cells),
        .ser_out(ser_out)
    );

    pixsel_gate #(.LEN(LEN)) gate_i (
        .cells  (cells),
        .sel_en (sel_en),
        .sel_out(sel_out)
    );

    for (genvar h = 0; h < NUM_HALF; h++) begin : g_half
        pixsel_occ occ_i (
            .bits(cells[h*HALF_W +: HALF_W]),
            .occ (half_occ[h])
        );
        assign half_many[h] = (half_occ[h] == OCC_MANY);
    end

    assign col_onehot = (half_occ[0] == OCC_ONE);

    if (NUM_HALF > 1) begin : g_rows
        assign row_onehot = (half_occ[1] == OCC_ONE);
    end else begin : g_no_rows
        assign row_onehot = 1'b1;
    end

    assign single_pixel = col_onehot & row_onehot;
    assign multi_select = |half_many;

endmodule

// File: rtl/pixsel_sr_chk.sv
module pixsel_sr_chk #(
    parameter int LEN = 32
) (
    input logic           clk_sh,
    input logic           rst_n,
    input logic           ser_in,
    input logic           sel_en,
    input logic [LEN-1:0] sel_out,
    input logic           ser_out,
    input logic           col_onehot,
    input logic           row_onehot,
    input logic           single_pixel,
    input logic           multi_select
);

    assert_gate_low_R4: assert property (@(posedge clk_sh) disable iff (!rst_n)
        !sel_en |-> sel_out == '0);

    assert_ser_capture_R2: assert property (@(posedge clk_sh) disable iff (!rst_n)
        sel_en |=> (!sel_en || sel_out[LEN-1] == $past(ser_in)));

    assert_shift_down_R12: assert property (@(posedge clk_sh) disable iff (!rst_n)
        sel_en |=> (!sel_en || sel_out[LEN-2:0] == $past(sel_out[LEN-1:1])));

    assert_ser_out_R6: assert property (@(posedge clk_sh) disable iff (!rst_n)
        sel_en |-> ser_out == sel_out[0]);

    assert_col_onehot_R7: assert property (@(posedge clk_sh) disable iff (!rst_n)
        sel_en |-> col_onehot == ($countones(sel_out[15:0]) == 1));

    assert_multi_R10: assert property (@(posedge clk_sh) disable iff (!rst_n)
        (sel_en && $countones(sel_out[15:0]) > 1) |-> multi_select);

    assert_single_R9: assert property (@(posedge clk_sh) disable iff (!rst_n)
        single_pixel |-> (col_onehot && row_onehot && !multi_select));

endmodule

bind pixsel_sr pixsel_sr_chk #(.LEN(LEN)) chk_i (
    .clk_sh      (clk_sh),
    .rst_n       (rst_n),
    .ser_in      (ser_in),
    .sel_en      (sel_en),
    .sel_out     (sel_out),
    .ser_out     (ser_out),
    .col_onehot  (col_onehot),
    .row_onehot  (row_onehot),
    .single_pixel(single_pixel),
    .multi_select(multi_select)
);

// File: tb/pixsel_sr_tb_top.sv
module pixsel_sr_tb_top;

    logic clk_sh = 1'b0;
    always #5 clk_sh = ~clk_sh;

    logic        rst_n = 1'b0;
    logic        ser_in = 1'b0;
    logic        sel_en = 1'b0;
    logic [31:0] sel_out;
    logic        ser_out, col_onehot, row_onehot, single_pixel, multi_select;
    logic [15:0] sel_out16;
    logic        ser_out16, c16, r16, s16, m16;

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    pixsel_sr #(.LEN(32)) dut_i (
        .clk_sh(clk_sh), .rst_n(rst_n), .ser_in(ser_in), .sel_en(sel_en),
        .sel_out(sel_out), .ser_out(ser_out), .col_onehot(col_onehot),
        .row_onehot(row_onehot), .single_pixel(single_pixel),
        .multi_select(multi_select)
    );

    pixsel_sr #(.LEN(16)) dut16_i (
        .clk_sh(clk_sh), .rst_n(rst_n), .ser_in(ser_in), .sel_en(sel_en),
        .sel_out(sel_out16), .ser_out(ser_out16), .col_onehot(c16),
        .row_onehot(r16), .single_pixel(s16), .multi_select(m16)
    );

    // {pattern, col_onehot, row_onehot, single_pixel, multi_select}
    localparam logic [35:0] VEC [8] = '{
        {32'h0001_0001, 4'b1110},
        {32'h8000_8000, 4'b1110},
        {32'h0003_0001, 4'b1001},
        {32'h0000_0000, 4'b0000},
        {32'h0001_0006, 4'b0101},
        {32'h0000_0100, 4'b1000},
        {32'hFFFF_FFFF, 4'b0001},
        {32'h4000_0000, 4'b0100}
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk_sh);
        rst_n  = 1'b0;
        sel_en = 1'b0;
        ser_in = 1'b0;
        @(negedge clk_sh);
        rst_n  = 1'b1;
    endtask

    // stream bit k is sent k-th; returns at the negedge after the last capture
    task automatic load(input logic [31:0] pat, input int n, input bit zero_chk);
        for (int k = 0; k < n; k++) begin
            @(negedge clk_sh);
            if (zero_chk) chk("R4 gated while loading", sel_out, 32'h0);
            ser_in = pat[k];
        end
        @(negedge clk_sh);
    endtask

    initial begin
        #1_000_000;
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        // R3 reset state
        do_reset();
        chk("R3 reset ser_out", 32'(ser_out), 32'h0);
        chk("R3 reset flags", {28'h0, col_onehot, row_onehot, single_pixel, multi_select}, 32'h0);

        // table walk: R2 R4 R5 R6 R7 R8 R9 R10
        for (int v = 0; v < 8; v++) begin
            logic [31:0] pat;
            pat = VEC[v][35:4];
            do_reset();
            load(pat, 32, 1'b1);
            chk("R4 gate low after load", sel_out, 32'h0);
            chk("R7 col_onehot", 32'(col_onehot), 32'(VEC[v][3]));
            chk("R8 row_onehot", 32'(row_onehot), 32'(VEC[v][2]));
            chk("R9 single_pixel", 32'(single_pixel), 32'(VEC[v][1]));
            chk("R10 multi_select", 32'(multi_select), 32'(VEC[v][0]));
            sel_en = 1'b1;
            #1;
            chk("R5 R2 column/row placement", sel_out, pat);
            chk("R6 ser_out exit cell", 32'(ser_out), 32'(pat[0]));
            sel_en = 1'b0;
        end

        // R12 shifting with gate open
        do_reset();
        sel_en = 1'b1;
        ser_in = 1'b1;
        @(negedge clk_sh);
        chk("R12 first shift visible", sel_out, 32'h8000_0000);
        ser_in = 1'b0;
        @(negedge clk_sh);
        chk("R12 second shift visible", sel_out, 32'h4000_0000);
        @(negedge clk_sh);
        chk("R12 third shift visible", sel_out, 32'h2000_0000);

        // R6 readback of successive bits
        do_reset();
        load(32'hA5C3_0F96, 32, 1'b0);
        chk("R6 ser_out bit0", 32'(ser_out), 32'h0);
        ser_in = 1'b0;
        for (int j = 1; j < 4; j++) begin
            @(negedge clk_sh);
            chk("R6 ser_out next bit", 32'(ser_out), 32'((32'hA5C3_0F96 >> j) & 1));
        end

        // R11 enable toggling does not touch contents
        do_reset();
        load(32'h0001_0001, 32, 1'b0);
        sel_en = 1'b1; #1;
        sel_en = 1'b0; #1;
        chk("R11 gate low", sel_out, 32'h0);
        sel_en = 1'b1; #1;
        chk("R11 contents kept", sel_out, 32'h0001_0001);
        chk("R11 flags kept", 32'(single_pixel), 32'h1);
        sel_en = 1'b0;

        // R3 asynchronous clear mid-cycle with gate open
        do_reset();
        load(32'hFFFF_FFFF, 32, 1'b0);
        sel_en = 1'b1;
        #2;
        rst_n = 1'b0;
        #1;
        chk("R3 async clear outputs", sel_out, 32'h0);
        chk("R3 async clear flags", {28'h0, col_onehot, row_onehot, single_pixel, multi_select}, 32'h0);
        chk("R3 async clear ser_out", 32'(ser_out), 32'h0);
        sel_en = 1'b0;
        @(negedge clk_sh);
        rst_n = 1'b1;

        // R1 R8 sixteen-cell form
        do_reset();
        load(32'h0000_0020, 16, 1'b0);
        sel_en = 1'b1; #1;
        chk("R1 16-cell outputs", 32'(sel_out16), 32'h0000_0020);
        chk("R8 16-cell row flag held", 32'(r16), 32'h1);
        chk("R9 16-cell single", 32'(s16), 32'h1);
        sel_en = 1'b0;
        do_reset();
        load(32'h0000_0021, 16, 1'b0);
        chk("R10 16-cell multi", 32'(m16), 32'h1);
        chk("R7 16-cell col flag", 32'(c16), 32'h0);
        chk("R1 16-cell gated", 32'(sel_out16), 32'h0);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule